// File: doc/BRIEF.md
# SPI Baud Divisor Search Engine

This engine picks the clock divider setting for an SPI controller whose bit clock comes from a two-stage divider. The first stage is a power-of-two pre-scaler with exponent 0 to 7. The second is an integer scaler from 1 to 15. A start strobe captures a 32-bit reference frequency and a 32-bit requested frequency. The engine then tries every pre-scaler exponent in ascending order. For each one it computes the smallest scaler whose output does not exceed the request, and it keeps the candidate with the smallest shortfall.

The two divisions for each candidate run on a single radix-2 restoring divider that takes 32 cycles per division. When the search ends, the engine packs the winning exponent and scaler into one byte for the controller's configuration register and pulses `done`. If no candidate was usable, or if the requested frequency is zero, it raises `err` instead.

Top module: `spi_baud_search`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and `prescale` is 0x00. `prescale` and `err` change only in a cycle where `done` is 1.
- R2: `busy` is 1 from the cycle after an accepted start until the search ends. `done` is then a single-cycle pulse, and `busy` is 0 in that cycle.
- R3: A start pulse while `busy` is 1 is ignored. The inputs are captured at the accepted start, so the result reflects only that first request.
- R4: For exponent p, the scaler is the ceiling of floor(ref/2^p) divided by req. A candidate whose scaler is 0 or above 15 is skipped.
- R5: The achieved clock is floor(ref/(scaler·2^p)) and never exceeds req. The winner is the candidate with the smallest value of req minus the achieved clock, and the starting best error equals req.
- R6: On equal error the candidate with the lower exponent wins.
- R7: If no candidate improves on the starting error, `err` is 1 and `prescale` is 0x00 at `done`.
- R8: A start with req equal to 0 gives `done` and `err` in the next cycle, without a search.
- R9: Packing: `prescale[7:6]` holds exponent bits 2:1, `prescale[5]` is 0, `prescale[4]` holds exponent bit 0, and `prescale[3:0]` holds the scaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, sampled when idle |
| ref_hz | input | 32 | Reference clock frequency |
| req_hz | input | 32 | Requested SPI clock frequency |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| prescale | output | 8 | Packed divider setting |
| err | output | 1 | No usable setting found |

## Verification
Two events can land on the same edge: the search finishing with its `done` pulse, and a new start request arriving. The bench pulses `start` with different operands while the engine is busy and checks that the result still matches the first request. It also starts a new search in the cycle right after `done`, to show that a start is accepted as soon as the engine is idle again. A second coincidence is two candidates with equal error. The vector table includes a case where a later exponent reaches the same shortfall, and the bench expects the earlier exponent to win.

// File: rtl/spi_baud_search.sv
module spi_baud_search #(
  parameter int W  = 32,
  parameter int PW = 3,
  parameter int SW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] ref_hz,
  input  logic [W-1:0] req_hz,
  output logic         busy,
  output logic         done,
  output logic [7:0]   prescale,
  output logic         err
);
  localparam int CW   = $clog2(W);
  localparam int NPRE = 1 << PW;
  localparam int SMAX = (1 << SW) - 1;

  typedef enum logic [2:0] {ST_IDLE, ST_DIV1, ST_CEIL, ST_DIV2, ST_EVAL, ST_ADV} st_t;
  st_t state;

  logic [W-1:0]  ref_q, req_q, dvd, dvs, best_err;
  logic [W:0]    rem;
  logic [CW-1:0] cnt;
  logic [PW-1:0] p, best_p;
  logic [SW-1:0] spr, best_spr;

  logic [W:0]   rem_sh, rem_nx, quo_ceil;
  logic         fits;
  logic [W-1:0] err_c;

  assign rem_sh   = {rem[W-1:0], dvd[W-1]};
  assign fits     = rem_sh >= {1'b0, dvs};
  assign rem_nx   = fits ? rem_sh - {1'b0, dvs} : rem_sh;
  assign quo_ceil = {1'b0, dvd} + {{W{1'b0}}, |rem};
  assign err_c    = req_q - dvd;
  assign busy     = state != ST_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ref_q    <= '0;
      req_q    <= '0;
      dvd      <= '0;
      dvs      <= '0;
      rem      <= '0;
      cnt      <= '0;
      p        <= '0;
      spr      <= '0;
      best_p   <= '0;
      best_spr <= '0;
      best_err <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      prescale <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (req_hz == '0) begin
            done     <= 1'b1;
            err      <= 1'b1;
            prescale <= '0;
          end else begin
            ref_q    <= ref_hz;
            req_q    <= req_hz;
            p        <= '0;
            best_p   <= '0;
            best_spr <= '0;
            best_err <= req_hz;
            dvd      <= ref_hz;
            dvs      <= req_hz;
            rem      <= '0;
            cnt      <= '0;
            state    <= ST_DIV1;
          end
        end
        ST_DIV1, ST_DIV2: begin
          rem <= rem_nx;
          dvd <= {dvd[W-2:0], fits};
          cnt <= cnt + CW'(1);
          if (cnt == CW'(W-1))
            state <= (state == ST_DIV1) ? ST_CEIL : ST_EVAL;
        end
        ST_CEIL: begin
          if (quo_ceil == '0 || quo_ceil > (W+1)'(SMAX)) begin
            state <= ST_ADV;
          end else begin
            spr   <= quo_ceil[SW-1:0];
            dvd   <= ref_q;
            dvs   <= W'(quo_ceil[SW-1:0]) << p;
            rem   <= '0;
            cnt   <= '0;
            state <= ST_DIV2;
          end
        end
        ST_EVAL: begin
          if (err_c < best_err) begin
            best_err <= err_c;
            best_spr <= spr;
            best_p   <= p;
          end
          state <= ST_ADV;
        end
        ST_ADV: begin
          if (p == PW'(NPRE-1)) begin
            done     <= 1'b1;
            err      <= (best_spr == '0) && (best_p == '0);
            prescale <= {best_p[2:1], 1'b0, best_p[0], best_spr};
            state    <= ST_IDLE;
          end else begin
            p     <= p + PW'(1);
            dvd   <= ref_q >> (p + PW'(1));
            dvs   <= req_q;
            rem   <= '0;
            cnt   <= '0;
            state <= ST_DIV1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

module spi_baud_search_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] req_hz,
  input logic        busy,
  input logic        done,
  input logic [7:0]  prescale,
  input logic        err
);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R8
  zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && req_hz == 32'd0) |=> (done && err));
  // R9
  pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (!prescale[5] && prescale[3:0] != 4'd0));
  // R7
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && err) |-> prescale == 8'd0);
  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(prescale) && $stable(err)));
endmodule

bind spi_baud_search spi_baud_search_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .req_hz(req_hz),
  .busy(busy), .done(done), .prescale(prescale), .err(err)
);

// File: tb/spi_baud_search_tb.sv
module spi_baud_search_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] ref_hz = '0, req_hz = '0;
  logic busy, done, err;
  logic [7:0] prescale;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  spi_baud_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz), .req_hz(req_hz),
    .busy(busy), .done(done), .prescale(prescale), .err(err)
  );

  // {ref, req, expected prescale, expected err}
  localparam int NV = 8;
  localparam logic [72:0] VEC [NV] = '{
    {32'd100,       32'd10,      8'h0A, 1'b0},  // R5 exact at p0
    {32'd1000,      32'd7,       8'hD1, 1'b0},  // R4 skips, best at p7
    {32'd100000,    32'd10,      8'h00, 1'b1},  // R7 all scalers > 15
    {32'd10,        32'd100,     8'h01, 1'b0},  // R4 zero scaler skipped
    {32'd1000,      32'd250,     8'h04, 1'b0},  // R6 earliest exact wins
    {32'd200000000, 32'd1000000, 8'h8D, 1'b0},  // R9 p=4 s=13
    {32'd96,        32'd3,       8'h48, 1'b0},  // R9 p=2 s=8
    {32'd96,        32'd6,       8'h18, 1'b0}   // R9 p=1 s=8
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] r, input logic [31:0] q, output int cyc);
    bit busy_ok = 1'b1;
    ref_hz = r; req_hz = q; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      if (!busy) busy_ok = 1'b0;
      @(negedge clk); cyc++;
    end
    chk(done, "R2 done timeout", 32'(done), 32'd1);
    chk(busy_ok && !busy, "R2 busy window", 32'(busy_ok), 32'd1);
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err && prescale == 8'h00, "R1 reset", {prescale, 5'd0, busy, done, err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][72:41], VEC[i][40:9], cyc);
      chk(prescale == VEC[i][8:1], "R5/R9 prescale", 32'(prescale), 32'(VEC[i][8:1]));
      chk(err == VEC[i][0], "R7 err", 32'(err), 32'(VEC[i][0]));
      @(negedge clk);
      chk(!done, "R2 single pulse", 32'(done), 32'd0);
    end

    // R8 zero request finishes one cycle after start
    run(32'd1000, 32'd0, cyc);
    chk(cyc == 1, "R8 latency", 32'(cyc), 32'd1);
    chk(err && prescale == 8'h00, "R8 err", {prescale, 7'd0, err}, 32'd1);

    // R3 start while busy is ignored
    ref_hz = 32'd100; req_hz = 32'd10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    ref_hz = 32'd96; req_hz = 32'd6; start = 1'b1;
    @(negedge clk); start = 1'b0;
    ref_hz = 32'd100000; req_hz = 32'd10;
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(prescale == 8'h0A && !err, "R3 ignored start", 32'(prescale), 32'h0A);
    // R1 output held after done
    ref_hz = 32'd96; req_hz = 32'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && prescale == 8'h0A, "R1 hold while busy", 32'(prescale), 32'h0A);
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(prescale == 8'h48, "R3 start right after done", 32'(prescale), 32'h48);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule